// File: doc/BRIEF.md
# Interleaved Half-Line SECDED Codec

This block protects a 256-bit half-line held in memory built from 4-bit-wide devices. The half-line is split into four independent 72-bit SECDED codewords, each carrying 64 data bits and 8 check bits. The stored 288-bit image is laid out so that every device (four adjacent stored bits) gives exactly one bit to each of the four codewords. Any fault pattern confined to one device therefore shows up as at most one flipped bit per codeword, and the codec corrects it.

The encode path turns 256 data bits into the 288-bit stored image. The decode path takes a stored image and returns the 256 corrected data bits together with a per-word correctable flag and a per-word uncorrectable flag. Both paths are combinational. A parameter adds one register stage on all outputs, and that stage is cleared by reset.

Top module: `ilv_half_line_codec`

## Requirements
- R1: Codeword k (k = 0..3) carries data bits 64k..64k+63. Codeword bit j (j < 64) is data bit 64k+j, bits 64..70 are check bits c0..c6, and bit 71 is the overall check bit. Codeword k bit d is stored at image bit 4d+k, for d = 0..71.
- R2: The data bits take Hamming positions 3, 5, 6, 7, 9, … in ascending order, which are the non-powers-of-two below 128, taken in turn. Check bit c (c < 7) is the XOR of the data bits whose position has bit c set. The overall check bit makes the XOR of all 72 bits of the codeword zero.
- R3: A stored image with no flipped bit decodes to the original data with all correctable and uncorrectable flags clear.
- R4: A single flipped bit anywhere in a codeword, including in the check bits, is corrected. The word's correctable flag (dec_ce_o bit k) is set and its data comes out exact.
- R5: Two flipped bits within one codeword set that word's uncorrectable flag (dec_ue_o bit k). That word's data is then passed through uncorrected: output bit 64k+j equals stored image bit 4j+k.
- R6: Any nonzero fault pattern on the four stored bits 4d..4d+3 of one device is fully corrected. Each affected word raises its correctable flag.
- R7: The words are decoded independently. A word with no flipped bit keeps both of its flags clear and its data exact, whatever happens in the other words.
- R8: For each word, the correctable flag and the uncorrectable flag are never set together.
- R9: With OUT_REG = 1 (the default), every output reflects the inputs one clock earlier. While rst_ni is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enc_data_i | input | 256 | Half-line data to encode |
| enc_code_o | output | 288 | Interleaved stored image |
| dec_code_i | input | 288 | Stored image to decode |
| dec_data_o | output | 256 | Corrected data |
| dec_ce_o | output | 4 | Per-word correctable error flag |
| dec_ue_o | output | 4 | Per-word uncorrectable error flag |

## Verification
The assertions assume that each codeword holds at most two flipped bits. Beyond that limit a SECDED decode can miscorrect, so the claims about single-flip and pass-through no longer hold. The stimulus stays inside this limit. It applies clean images, every single-bit position of the 288-bit image, random double faults confined to one word, whole-device faults with random nonzero nibbles, and single faults in all four words at once. No word ever receives a third flipped bit.

// File: rtl/ilv_secded_pkg.sv
package ilv_secded_pkg;
  localparam int unsigned WORD_DW = 64;
  localparam int unsigned CHK_W   = 8;
  localparam int unsigned HAM_W   = CHK_W - 1;
  localparam int unsigned WORD_W  = WORD_DW + CHK_W;
  localparam int unsigned N_WORDS = 4;
  localparam int unsigned LINE_DW = WORD_DW * N_WORDS;
  localparam int unsigned LINE_W  = WORD_W * N_WORDS;

  // Hamming position of data bit j: j-th non-power-of-two from 3 upward
  function automatic logic [HAM_W-1:0] data_pos(int unsigned j);
    int unsigned n;
    logic [HAM_W-1:0] r;
    n = 0;
    r = '0;
    for (int unsigned p = 3; p < (1 << HAM_W); p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == j) r = p[HAM_W-1:0];
        n++;
      end
    end
    return r;
  endfunction

  // Check-matrix column of codeword bit b
  function automatic logic [CHK_W-1:0] h_col(int unsigned b);
    logic [HAM_W-1:0] one;
    one = 1;
    if (b < WORD_DW)          return {1'b1, data_pos(b)};
    else if (b < WORD_W - 1)  return {1'b1, one << (b - WORD_DW)};
    else                      return {1'b1, {HAM_W{1'b0}}};
  endfunction

  function automatic logic [WORD_W-1:0] h_row(int unsigned i);
    logic [WORD_W-1:0] r;
    logic [CHK_W-1:0]  c;
    for (int unsigned b = 0; b < WORD_W; b++) begin
      c    = h_col(b);
      r[b] = c[i];
    end
    return r;
  endfunction

  function automatic logic [WORD_DW-1:0] data_mask(int unsigned i);
    logic [WORD_DW-1:0] r;
    logic [HAM_W-1:0]   p;
    for (int unsigned j = 0; j < WORD_DW; j++) begin
      p    = data_pos(j);
      r[j] = p[i];
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_word_enc.sv
module secded_word_enc
  import ilv_secded_pkg::*;
(
  input  logic [WORD_DW-1:0] data_i,
  output logic [WORD_W-1:0]  code_o
);
  logic [HAM_W-1:0] chk;

  for (genvar c = 0; c < HAM_W; c++) begin : g_chk
    localparam logic [WORD_DW-1:0] MASK = data_mask(c);
    assign chk[c] = ^(data_i & MASK);
  end

  assign code_o = {^{chk, data_i}, chk, data_i};
endmodule

// File: rtl/secded_word_dec.sv
module secded_word_dec
  import ilv_secded_pkg::*;
(
  input  logic [WORD_W-1:0]  code_i,
  output logic [WORD_DW-1:0] data_o,
  output logic               ce_o,
  output logic               ue_o
);
  logic [CHK_W-1:0]  syn;
  logic [WORD_W-1:0] flip;

  for (genvar i = 0; i < CHK_W; i++) begin : g_syn
    localparam logic [WORD_W-1:0] ROW = h_row(i);
    assign syn[i] = ^(code_i & ROW);
  end

  // one comparator per column; at most one can hit
  for (genvar b = 0; b < WORD_W; b++) begin : g_match
    localparam logic [CHK_W-1:0] COL = h_col(b);
    assign flip[b] = (syn == COL);
  end

  assign ce_o   = |flip;
  assign ue_o   = (syn != '0) && !ce_o;
  assign data_o = code_i[WORD_DW-1:0] ^ flip[WORD_DW-1:0];
endmodule

// File: rtl/ilv_half_line_codec.sv
module ilv_half_line_codec
  import ilv_secded_pkg::*;
#(
  parameter int unsigned OUT_REG = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LINE_DW-1:0] enc_data_i,
  output logic [LINE_W-1:0]  enc_code_o,
  input  logic [LINE_W-1:0]  dec_code_i,
  output logic [LINE_DW-1:0] dec_data_o,
  output logic [N_WORDS-1:0] dec_ce_o,
  output logic [N_WORDS-1:0] dec_ue_o
);
  logic [WORD_W-1:0]  enc_cw [N_WORDS];
  logic [WORD_W-1:0]  dec_cw [N_WORDS];
  logic [LINE_W-1:0]  code_c;
  logic [LINE_DW-1:0] data_c;
  logic [N_WORDS-1:0] ce_c, ue_c;

  for (genvar k = 0; k < N_WORDS; k++) begin : g_word
    secded_word_enc u_enc (
      .data_i (enc_data_i[k*WORD_DW +: WORD_DW]),
      .code_o (enc_cw[k])
    );
    // device d owns image bits N_WORDS*d .. N_WORDS*d+N_WORDS-1
    for (genvar d = 0; d < WORD_W; d++) begin : g_ilv
      assign code_c[d*N_WORDS + k] = enc_cw[k][d];
      assign dec_cw[k][d]          = dec_code_i[d*N_WORDS + k];
    end
    secded_word_dec u_dec (
      .code_i (dec_cw[k]),
      .data_o (data_c[k*WORD_DW +: WORD_DW]),
      .ce_o   (ce_c[k]),
      .ue_o   (ue_c[k])
    );
  end

  if (OUT_REG != 0) begin : g_oreg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        enc_code_o <= '0;
        dec_data_o <= '0;
        dec_ce_o   <= '0;
        dec_ue_o   <= '0;
      end else begin
        enc_code_o <= code_c;
        dec_data_o <= data_c;
        dec_ce_o   <= ce_c;
        dec_ue_o   <= ue_c;
      end
    end
  end else begin : g_comb
    assign enc_code_o = code_c;
    assign dec_data_o = data_c;
    assign dec_ce_o   = ce_c;
    assign dec_ue_o   = ue_c;
  end
endmodule

// File: rtl/ilv_half_line_codec_chk.sv
module ilv_half_line_codec_chk
  import ilv_secded_pkg::*;
#(
  parameter int unsigned OUT_REG = 1
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [LINE_DW-1:0] enc_data_i,
  input logic [LINE_W-1:0]  enc_code_o,
  input logic [LINE_W-1:0]  dec_code_i,
  input logic [LINE_DW-1:0] dec_data_o,
  input logic [N_WORDS-1:0] dec_ce_o,
  input logic [N_WORDS-1:0] dec_ue_o
);
  logic [LINE_DW-1:0] a_enc;
  logic [LINE_W-1:0]  a_dec;
  logic               a_v;

  if (OUT_REG != 0) begin : g_align
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_enc <= '0;
        a_dec <= '0;
        a_v   <= 1'b0;
      end else begin
        a_enc <= enc_data_i;
        a_dec <= dec_code_i;
        a_v   <= 1'b1;
      end
    end
  end else begin : g_align
    assign a_enc = enc_data_i;
    assign a_dec = dec_code_i;
    assign a_v   = 1'b1;
  end

  logic [LINE_DW-1:0] img_data;
  logic [LINE_DW-1:0] raw_data;
  always_comb begin
    for (int k = 0; k < N_WORDS; k++)
      for (int j = 0; j < WORD_DW; j++) begin
        img_data[k*WORD_DW + j] = enc_code_o[j*N_WORDS + k];
        raw_data[k*WORD_DW + j] = a_dec[j*N_WORDS + k];
      end
  end

  p_enc_systematic_r1: assert property (@(posedge clk_i) disable iff (!rst_ni || !a_v)
    img_data == a_enc);

  for (genvar k = 0; k < N_WORDS; k++) begin : g_w
    wire [WORD_DW-1:0] d_o = dec_data_o[k*WORD_DW +: WORD_DW];
    wire [WORD_DW-1:0] d_r = raw_data[k*WORD_DW +: WORD_DW];

    p_flags_excl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !a_v)
      !(dec_ce_o[k] && dec_ue_o[k]));
    p_clean_exact_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || !a_v)
      (!dec_ce_o[k] && !dec_ue_o[k]) |-> (d_o == d_r));
    p_ue_raw_r5: assert property (@(posedge clk_i) disable iff (!rst_ni || !a_v)
      dec_ue_o[k] |-> (d_o == d_r));
    p_ce_single_flip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni || !a_v)
      dec_ce_o[k] |-> ($countones(d_o ^ d_r) <= 1));
  end
endmodule

bind ilv_half_line_codec ilv_half_line_codec_chk #(.OUT_REG(OUT_REG)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .enc_data_i (enc_data_i),
  .enc_code_o (enc_code_o),
  .dec_code_i (dec_code_i),
  .dec_data_o (dec_data_o),
  .dec_ce_o   (dec_ce_o),
  .dec_ue_o   (dec_ue_o)
);

// File: tb/sim_ilv_half_line_codec.sv
module sim_ilv_half_line_codec;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [255:0] enc_data_i = '0;
  logic [287:0] dec_code_i = '0;
  logic [287:0] enc_code_o;
  logic [255:0] dec_data_o;
  logic [3:0]   dec_ce_o, dec_ue_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ilv_half_line_codec u0 (.*);

  logic [287:0] e_code;
  logic [255:0] e_data;
  logic [3:0]   e_ce, e_ue;
  string        e_tag;
  bit           have = 0;

  // reference from R1/R2 wording: positions, parity, interleave
  function automatic logic [287:0] ref_enc(logic [255:0] d);
    logic [287:0] img;
    logic [71:0]  cw;
    logic [127:0] ham;
    int n;
    logic par;
    img = '0;
    for (int w = 0; w < 4; w++) begin
      ham = '0;
      n = 0;
      for (int p = 1; p < 128; p++)
        if ((p & (p - 1)) != 0 && n < 64) begin
          ham[p] = d[64*w + n];
          n++;
        end
      cw[63:0] = d[64*w +: 64];
      for (int c = 0; c < 7; c++) begin
        par = 1'b0;
        for (int p = 1; p < 128; p++)
          if (((p >> c) & 1) == 1) par ^= ham[p];
        cw[64 + c] = par;
      end
      cw[71] = ^cw[70:0];
      for (int i = 0; i < 72; i++) img[4*i + w] = cw[i];
    end
    return img;
  endfunction

  task automatic chk(input string what, input logic [287:0] act, input logic [287:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", e_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk("enc_code", enc_code_o, e_code);
    chk("dec_data", {32'd0, dec_data_o}, {32'd0, e_data});
    chk("dec_ce", {284'd0, dec_ce_o}, {284'd0, e_ce});
    chk("dec_ue", {284'd0, dec_ue_o}, {284'd0, e_ue});
    chk("R8 excl", {284'd0, dec_ce_o & dec_ue_o}, 288'd0);
  endtask

  task automatic step(input logic [255:0] d, input logic [287:0] m, input string tag);
    logic [287:0] img, bad;
    int cnt;
    @(negedge clk_i);
    if (have) compare();
    img = ref_enc(d);
    bad = img ^ m;
    enc_data_i = d;
    dec_code_i = bad;
    e_code = img;
    e_tag = tag;
    for (int w = 0; w < 4; w++) begin
      cnt = 0;
      for (int i = 0; i < 72; i++) cnt += int'(m[4*i + w]);
      e_ce[w] = (cnt == 1);
      e_ue[w] = (cnt >= 2);
      for (int j = 0; j < 64; j++)
        e_data[64*w + j] = (cnt >= 2) ? bad[4*j + w] : d[64*w + j];
    end
    have = 1;
  endtask

  function automatic logic [255:0] rnd256();
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[32*i +: 32] = $urandom;
    return r;
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [287:0] m;
    // R9: reset state, with nonzero inputs applied
    enc_data_i = '1;
    dec_code_i = '1;
    repeat (3) @(negedge clk_i);
    e_tag = "R9 reset";
    chk("enc_code", enc_code_o, '0);
    chk("dec_data", {32'd0, dec_data_o}, '0);
    chk("flags", {280'd0, dec_ce_o, dec_ue_o}, '0);
    rst_ni = 1'b1;

    // R1 R2 R3 R9: clean images
    step('0, '0, "R3 clean zero");
    step('1, '0, "R3 clean ones");
    step({64{4'ha}}, '0, "R1 clean pattern");
    for (int i = 0; i < 20; i++) step(rnd256(), '0, "R2 clean random");

    // R4: every single image bit
    for (int b = 0; b < 288; b++) begin
      m = '0;
      m[b] = 1'b1;
      step(rnd256(), m, "R4 single");
    end

    // R5 R7: double fault inside one word
    for (int w = 0; w < 4; w++)
      for (int i = 0; i < 20; i++) begin
        int d1, d2;
        d1 = $urandom % 72;
        d2 = (d1 + 1 + ($urandom % 71)) % 72;
        m = '0;
        m[4*d1 + w] = 1'b1;
        m[4*d2 + w] = 1'b1;
        step(rnd256(), m, "R5 R7 double");
      end

    // R6 R7: whole device fault, random nonzero nibble
    for (int d = 0; d < 72; d++) begin
      logic [3:0] nib;
      nib = 4'(1 + ($urandom % 15));
      m = '0;
      m[4*d +: 4] = nib;
      step(rnd256(), m, "R6 device");
    end
    m = '0;
    m[4*71 +: 4] = 4'hf;
    step('1, m, "R6 device top all");

    // R4 R7: one flip in each word at independent positions
    for (int i = 0; i < 20; i++) begin
      m = '0;
      for (int w = 0; w < 4; w++) m[4*($urandom % 72) + w] = 1'b1;
      step(rnd256(), m, "R4 R7 all words");
    end

    step('0, '0, "R9 flush");
    @(negedge clk_i);
    compare();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule